// File: doc/BRIEF.md
# Serial Port Host Register Block with Delayed Interrupts

This block presents the eight byte-wide host registers of a classic serial port to a simple processor bus and connects them to a character stream. Receive bytes come from a source that shows a valid flag and the byte at its head, and that advances when the block pops it. Transmit bytes go to a sink that takes one byte on each push. The block holds the interrupt enable, line control and modem control registers, and it forms the interrupt identification, line status and modem status values that the host reads. It does no bit timing, serial shifting or queueing.

Receive and transmit interrupts are not raised the moment their cause appears. Each one goes through its own delay timer of `DELAY` clock cycles, 450 by default. Restarting a timer reloads the full delay. A timer that runs out sets its pending bit only if its enable bit is still set at that moment. This spaces out interrupts, so a host driver that keeps reading while data keeps arriving is not flooded. The single interrupt output is the OR of the two pending bits.

Top module: `serial_regfile`

## Requirements
- R1: After reset, IER, LCR and MCR read 0, IIR reads 1, LSR reads 0x60 when no receive data is waiting, and `irq` is 0.
- R2: The low three address bits select the register: 0 data, 1 IER, 2 IIR (read) / FIFO control (write), 3 LCR, 4 MCR, 5 LSR, 6 MSR, 7 scratch. LCR reads back the last byte written. IER reads back the last byte written while bit 7 of LCR is clear. MSR and scratch read 0. Writes to the scratch and FIFO-control offsets change nothing. An access with any address bit above bit 2 set raises `bus_err` in that cycle, reads 0 and changes nothing.
- R3: While LCR bit 7 is set, accesses to offsets 0 and 1 read 0, pop nothing, push nothing and leave IER unchanged.
- R4: A data write with LCR bit 7 clear pushes the byte to the transmit sink at that edge and clears transmit pending. If IER bit 1 is set, it also restarts the transmit timer.
- R5: A data read with LCR bit 7 clear returns the head byte and pops it when data is available, and returns 0 with no pop otherwise. It clears receive pending. If data is still available on the next cycle and IER bit 0 is set, the receive timer restarts at that next edge.
- R6: An IER write with bit 1 set restarts the transmit timer. With bit 1 clear, it cancels that timer and clears transmit pending. With bit 0 set while data is available, it restarts the receive timer. Otherwise it cancels the receive timer and clears receive pending.
- R7: A timer restarted at edge k sets its pending bit at edge k+DELAY, provided its IER bit is set. A restart while the timer is running reloads the full delay.
- R8: An IIR read returns 0x00 while any interrupt is pending and 0x01 otherwise.
- R9: An LSR read always has bits 5 and 6 set, and bit 0 equals the receive valid flag.
- R10: Writing 0x1A to MCR stores 0x9A. Any other MCR write is ignored. MCR reads return the stored value.
- R11: `irq` is high exactly when a receive or transmit interrupt is pending. A receive byte that appears (valid rising) while IER bit 0 is set sets receive pending at the next edge, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while `bus_rd` is high |
| bus_err | output | 1 | Access outside offsets 0 to 7 |
| rx_valid | input | 1 | Receive source has a byte |
| rx_data | input | 8 | Head byte of the receive source |
| rx_pop | output | 1 | Consume the head byte at this edge |
| tx_push | output | 1 | Transmit sink takes `tx_data` at this edge |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
Read data, `bus_err`, `rx_pop` and `tx_push` are combinational in the access cycle. The scoreboard monitor therefore compares read data at the falling edge inside that cycle, and the error flag is sampled just after the inputs are driven. Pending bits and `irq` change at the edge that ends a write or a read, and the bench samples them 1 ns after that edge. A timer restarted by a write shows `irq` exactly DELAY edges after the write edge. The re-arm after a receive read starts one edge later, so its `irq` appears DELAY+1 edges after the read edge. For every delay the bench checks that `irq` is still low one edge before it is due and high on the edge it is due, so an off-by-one in either direction is reported.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } reg_ofs_e;

    // channel index doubles as its IER enable bit position
    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned CH_RX    = 0;
    localparam int unsigned CH_TX    = 1;
    localparam int unsigned DLAB_BIT = 7;

    localparam logic [7:0] MCR_PROBE     = 8'h1A;
    localparam logic [7:0] MCR_SIGNATURE = 8'h9A;
    localparam logic [7:0] LSR_TX_IDLE   = 8'h60;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ier_rd;
        logic ier_wr;
        logic iir_rd;
        logic lcr_rd;
        logic lcr_wr;
        logic mcr_rd;
        logic mcr_wr;
        logic lsr_rd;
        logic err;
    } strobe_t;

    typedef struct packed {
        logic [7:0]        ier;
        logic [7:0]        lcr;
        logic [7:0]        mcr;
        logic [NUM_CH-1:0] pend;
        logic              rechk;
        logic              rx_seen;
    } regs_t;

endpackage

// File: rtl/serial_reg_decode.sv
module serial_reg_decode
    import serial_regfile_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              dlab,
    output strobe_t           stb
);

    logic     in_range;
    logic     rd;
    logic     wr;
    reg_ofs_e ofs;

    generate
        if (ADDR_W > 3) begin : g_wide
            assign in_range = (bus_addr[ADDR_W-1:3] == '0);
        end else begin : g_narrow
            assign in_range = 1'b1;
        end
    endgenerate

    assign ofs = reg_ofs_e'(bus_addr[2:0]);
    assign rd  = bus_rd & in_range;
    assign wr  = bus_wr & in_range;

    always_comb begin
        stb     = '0;
        stb.err = (bus_rd | bus_wr) & ~in_range;
        unique case (ofs)
            OFS_DATA: begin
                stb.data_rd = rd & ~dlab;
                stb.data_wr = wr & ~dlab;
            end
            OFS_IER: begin
                stb.ier_rd = rd & ~dlab;
                stb.ier_wr = wr & ~dlab;
            end
            OFS_IIR: stb.iir_rd = rd;
            OFS_LCR: begin
                stb.lcr_rd = rd;
                stb.lcr_wr = wr;
            end
            OFS_MCR: begin
                stb.mcr_rd = rd;
                stb.mcr_wr = wr;
            end
            OFS_LSR: stb.lsr_rd = rd;
            default: ;
        endcase
    end

endmodule

// File: rtl/serial_intr_delay.sv
module serial_intr_delay #(
    parameter int unsigned DELAY = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    output logic fire
);

    localparam int unsigned CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign fire = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.run) begin
            if (fire) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
        if (restart) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = RELOAD;
        end
        if (cancel) begin
            tmr_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
    import serial_regfile_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DELAY  = 450
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    output logic              irq
);

    regs_t             regs_d, regs_q;
    strobe_t           stb;
    logic              dlab;
    logic              rx_rise;
    logic [NUM_CH-1:0] tmr_restart;
    logic [NUM_CH-1:0] tmr_cancel;
    logic [NUM_CH-1:0] tmr_fire;

    assign dlab = regs_q.lcr[DLAB_BIT];

    serial_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .dlab     (dlab),
        .stb      (stb)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tmr
            serial_intr_delay #(.DELAY(DELAY)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (tmr_restart[ch]),
                .cancel  (tmr_cancel[ch]),
                .fire    (tmr_fire[ch])
            );
        end
    endgenerate

    assign rx_rise = rx_valid & ~regs_q.rx_seen;

    // timer control
    always_comb begin
        tmr_restart = '0;
        tmr_cancel  = '0;
        if (stb.ier_wr) begin
            tmr_restart[CH_TX] = bus_wdata[CH_TX];
            tmr_cancel[CH_TX]  = ~bus_wdata[CH_TX];
            tmr_restart[CH_RX] = bus_wdata[CH_RX] & rx_valid;
            tmr_cancel[CH_RX]  = ~(bus_wdata[CH_RX] & rx_valid);
        end else begin
            tmr_restart[CH_TX] = stb.data_wr & regs_q.ier[CH_TX];
            tmr_restart[CH_RX] = regs_q.rechk & rx_valid & regs_q.ier[CH_RX];
        end
    end

    // next state: sets first, clears after, so clears win
    always_comb begin
        regs_d         = regs_q;
        regs_d.rx_seen = rx_valid;
        regs_d.rechk   = stb.data_rd;

        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (tmr_fire[ch] && regs_q.ier[ch]) begin
                regs_d.pend[ch] = 1'b1;
            end
        end
        if (rx_rise && regs_q.ier[CH_RX]) begin
            regs_d.pend[CH_RX] = 1'b1;
        end

        if (stb.data_rd) begin
            regs_d.pend[CH_RX] = 1'b0;
        end
        if (stb.data_wr) begin
            regs_d.pend[CH_TX] = 1'b0;
        end
        if (stb.ier_wr) begin
            regs_d.ier = bus_wdata;
            if (!bus_wdata[CH_TX]) begin
                regs_d.pend[CH_TX] = 1'b0;
            end
            if (!(bus_wdata[CH_RX] && rx_valid)) begin
                regs_d.pend[CH_RX] = 1'b0;
            end
        end
        if (stb.lcr_wr) begin
            regs_d.lcr = bus_wdata;
        end
        if (stb.mcr_wr && (bus_wdata == MCR_PROBE)) begin
            regs_d.mcr = MCR_SIGNATURE;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (stb.data_rd && rx_valid) bus_rdata = rx_data;
        if (stb.ier_rd)              bus_rdata = regs_q.ier;
        if (stb.iir_rd)              bus_rdata = {7'b0, ~(|regs_q.pend)};
        if (stb.lcr_rd)              bus_rdata = regs_q.lcr;
        if (stb.mcr_rd)              bus_rdata = regs_q.mcr;
        if (stb.lsr_rd)              bus_rdata = LSR_TX_IDLE | {7'b0, rx_valid};
    end

    assign bus_err = stb.err;
    assign rx_pop  = stb.data_rd & rx_valid;
    assign tx_push = stb.data_wr;
    assign tx_data = bus_wdata;
    assign irq     = |regs_q.pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_err,
    input logic              rx_valid,
    input logic              rx_pop,
    input logic              tx_push,
    input logic              irq,
    input logic              dlab
);

    // R5: a pop only happens on a read and only when a byte is waiting
    a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_valid && bus_rd));

    // R3: divisor-latch mode keeps the data offset away from the stream
    a_r3_dlab_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dlab && bus_addr == ADDR_W'(0)) |-> (!rx_pop && !tx_push));

    // R2: out-of-range access has no stream side effect
    a_r2_err_no_side: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!rx_pop && !tx_push));

    // R8: interrupt identification tracks the interrupt line
    a_r8_iir_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(2)) |-> (bus_rdata == {7'b0, !irq}));

    // R9: line status bits
    a_r9_lsr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(5)) |->
            (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_valid));

    // R6: disabling both interrupt sources leaves the line low next cycle
    a_r6_ier_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dlab && bus_addr == ADDR_W'(1) && (bus_wdata & 8'h03) == 8'h00)
            |=> !irq);

endmodule

bind serial_regfile serial_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/serial_regfile_tb.sv
`timescale 1ns/1ps
module serial_regfile_tb;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DELAY  = 450;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic              bus_err;
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic              rx_pop;
    logic              tx_push;
    logic [7:0]        tx_data;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;

    // receive source model
    logic [7:0] rx_mem [16];
    int rx_wp = 0;
    int rx_rp = 0;
    assign rx_valid = (rx_wp != rx_rp);
    assign rx_data  = rx_mem[rx_rp % 16];
    always @(posedge clk) if (rx_pop) rx_rp <= rx_rp + 1;

    // transmit sink model
    logic [7:0] tx_log [$];
    always @(posedge clk) if (tx_push) tx_log.push_back(tx_data);

    // scoreboard for reads
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    serial_regfile #(.ADDR_W(ADDR_W), .DELAY(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compare read data in the access cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 8'h00, 8'hFF);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk); #1;
        bus_rd   = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(tag, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_mem[rx_wp % 16] = b;
        rx_wp = rx_wp + 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        edges(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1;
        do_reset();

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(4'd1, 8'h00, "R1 IER reset");
        rd(4'd3, 8'h00, "R1 LCR reset");
        rd(4'd2, 8'h01, "R1 IIR reset");
        rd(4'd5, 8'h60, "R1 LSR reset");
        rd(4'd4, 8'h00, "R1 MCR reset");

        // R2 decode
        wr(4'd3, 8'h03);
        rd(4'd3, 8'h03, "R2 LCR readback");
        wr(4'd7, 8'h77);
        rd(4'd7, 8'h00, "R2 scratch reads 0");
        rd(4'd6, 8'h00, "R2 MSR reads 0");
        wr(4'd2, 8'hFF);
        rd(4'd2, 8'h01, "R2 FCR write no effect");
        bus_addr = 4'd9; bus_wdata = 8'hFF; bus_wr = 1'b1;
        #1 check("R2 bus_err on write", {7'b0, bus_err}, 8'h01);
        @(posedge clk); #1 bus_wr = 1'b0;
        rd(4'd12, 8'h00, "R2 out-of-range read 0");
        rd(4'd1, 8'h00, "R2 no alias to IER");
        check("R2 no tx push", 8'(tx_log.size()), 8'h00);

        // R6/R7 TX timer via IER
        wr(4'd1, 8'h02);
        edges(DELAY - 1);
        chk_irq(1'b0, "R7 tx irq not early");
        edges(1);
        chk_irq(1'b1, "R7 tx irq on time");
        rd(4'd2, 8'h00, "R8 IIR pending");
        rd(4'd1, 8'h02, "R2 IER readback");

        // R4 data write
        wr(4'd0, 8'h41);
        chk_irq(1'b0, "R4 tx pending cleared");
        check("R4 push count", 8'(tx_log.size()), 8'h01);
        if (tx_log.size() > 0) check("R4 push value", tx_log[0], 8'h41);
        edges(200);
        wr(4'd0, 8'h42);
        edges(DELAY - 1);
        chk_irq(1'b0, "R7 restart reloads");
        edges(1);
        chk_irq(1'b1, "R7 restart fires");

        // R6 cancel
        wr(4'd1, 8'h00);
        chk_irq(1'b0, "R6 tx disable clears");
        edges(DELAY + 10);
        chk_irq(1'b0, "R6 tx timer cancelled");

        // R11 immediate RX on arrival
        wr(4'd1, 8'h01);
        chk_irq(1'b0, "R6 rx enable no data");
        push_rx(8'h5A);
        edges(1);
        chk_irq(1'b1, "R11 rx arrival raises irq");
        rd(4'd5, 8'h61, "R9 LSR data ready");
        push_rx(8'h33);
        rd(4'd0, 8'h5A, "R5 read head byte");
        chk_irq(1'b0, "R5 read clears rx pending");
        edges(DELAY);
        chk_irq(1'b0, "R5 rearm not early");
        edges(1);
        chk_irq(1'b1, "R5 rearm fires");
        rd(4'd0, 8'h33, "R5 read second byte");
        edges(DELAY + 5);
        chk_irq(1'b0, "R5 no rearm when empty");
        rd(4'd0, 8'h00, "R5 empty read 0");
        rd(4'd5, 8'h60, "R9 LSR empty");

        // R11 arrival with enable clear, then R6 start with data present
        wr(4'd1, 8'h00);
        push_rx(8'h77);
        edges(2);
        chk_irq(1'b0, "R11 no irq when disabled");
        wr(4'd1, 8'h01);
        edges(DELAY - 1);
        chk_irq(1'b0, "R6 rx timer not early");
        edges(1);
        chk_irq(1'b1, "R6 rx timer fires");
        wr(4'd1, 8'h00);
        chk_irq(1'b0, "R6 rx disable clears");
        rd(4'd0, 8'h77, "R5 drain byte");

        // R3 divisor-latch mode
        wr(4'd3, 8'h83);
        push_rx(8'h11);
        wr(4'd0, 8'h99);
        check("R3 no push in DLAB", 8'(tx_log.size()), 8'h02);
        wr(4'd1, 8'hFF);
        rd(4'd0, 8'h00, "R3 data read in DLAB");
        rd(4'd1, 8'h00, "R3 IER read in DLAB");
        wr(4'd3, 8'h03);
        rd(4'd1, 8'h00, "R3 IER untouched");
        rd(4'd5, 8'h61, "R3 no pop in DLAB");
        rd(4'd0, 8'h11, "R3 byte still there");
        chk_irq(1'b0, "R3 irq quiet");

        // R10 MCR probe
        wr(4'd4, 8'h55);
        rd(4'd4, 8'h00, "R10 other write ignored");
        wr(4'd4, 8'h1A);
        rd(4'd4, 8'h9A, "R10 probe signature");
        wr(4'd4, 8'h10);
        rd(4'd4, 8'h9A, "R10 signature kept");

        // R1 reset again
        do_reset();
        rd(4'd4, 8'h00, "R1 MCR after reset");
        rd(4'd3, 8'h00, "R1 LCR after reset");

        edges(2);
        if (exp_q.size() != 0) check("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule